// File: doc/BRIEF.md
# Oscillator Band Search Controller

This block chooses one of 24 oscillator bands so that the loop tuning voltage settles inside a narrow safe window. Software gives a starting band, an enable for the automatic search, and a start strobe. The strobe is raised by the write that completes a new frequency word. While the search runs, the controller holds each candidate band for a programmable settling time. It then reads a 3-bit tune-voltage ADC code and does one of three things: it accepts the band, steps the band index one place up, or steps it one place down.

The search ends in failure when a step would run past either end of the band range, or when it would return to a band already rejected in the same run. Two flags describe the outcome. A done flag is low while the search runs. A success flag tells a good finish apart from a failed or disabled one. With the automatic search disabled, the programmed band drives the oscillator directly. A software-commanded latch then copies the ADC code into a status field, and it does so only when the ADC read enable is set. The lock indication seen by the rest of the chip is masked while a search is in progress. A charge-pump control hand-off flag tells the pump whether the search logic or the fixed current setting controls its current.

Top module: `vco_band_search`

## Requirements
- R1: After reset, search_done_o is 1, search_ok_o is 0 and adc_status_o is 000.
- R2: A start_i pulse while auto_en_i is 1 starts a search at band min(band_prog_i, 23), and search_done_o is 0 from the next cycle. A start_i pulse while auto_en_i is 0 is ignored.
- R3: search_ok_o is 0 while a search runs, 1 after a success and 0 after a failure. It is also 0 whenever auto_en_i is 0.
- R4: ADC codes 010, 011, 100 and 101 accept the current band. Codes 000 and 001 step the band index up by one, and codes 110 and 111 step it down by one.
- R5: A search fails if the next step would go above band 23 or below band 0, or would land on a band already rejected in this run. After a failure, band_o keeps the last band tried.
- R6: Each band tried takes settle_cnt_i + 2 clock cycles. For a search that tries v bands, search_done_o rises v*(settle_cnt_i+2)+1 rising edges after the start edge, counting the start edge as edge 1.
- R7: When auto_en_i is 0, band_o equals min(band_prog_i, 23). When auto_en_i is 1, band_o is the band the search selected or is currently trying.
- R8: In manual mode (auto_en_i 0), adc_latch_i with adc_read_en_i set copies adc_code_i into adc_status_o on the next edge. A latch with adc_read_en_i clear leaves adc_status_o unchanged.
- R9: In auto mode, adc_status_o holds the last code sampled by the search, and adc_latch_i has no effect.
- R10: lock_o follows lock_raw_i except while a search runs, when it is 0.
- R11: A start_i pulse during a search restarts it from the newly programmed band with an empty set of rejected bands.
- R12: Clearing auto_en_i during a search aborts it. search_done_o is 1 and search_ok_o is 0 one edge later.
- R13: cp_auto_o is 1 only when both cp_sel_i and auto_en_i are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Search start strobe (frequency word completed) |
| auto_en_i | input | 1 | Automatic band search enable |
| band_prog_i | input | 5 | Programmed band: manual band or search start |
| settle_cnt_i | input | SETTLE_W | Settling cycles before each ADC sample |
| adc_code_i | input | 3 | Tune-voltage ADC code |
| adc_read_en_i | input | 1 | Manual ADC read enable |
| adc_latch_i | input | 1 | Manual ADC latch command |
| cp_sel_i | input | 1 | Give charge-pump current control to the search |
| lock_raw_i | input | 1 | Raw PLL lock detect |
| band_o | output | 5 | Active oscillator band |
| search_done_o | output | 1 | Search finished (0 while running) |
| search_ok_o | output | 1 | Search succeeded |
| cp_auto_o | output | 1 | Charge-pump current under search control |
| lock_o | output | 1 | Lock detect, masked during search |
| adc_status_o | output | 3 | Captured ADC code |

## Verification
The ADC is modelled by a function of the active band, and the bench sweeps every start index from 0 to 31 against every target band. From each result it predicts the final band, the flags, the captured code and the exact edge on which the done flag rises. This separates a correct walk direction and clamping from an off-by-one in the settle count. A second sweep uses an ADC model whose codes switch between the low class and the high class across a boundary. That makes the search bounce back to a band it has already rejected, and it shows whether the failure rule holds from both sides. Fixed codes 000 to 111 from a middle band cover every code class and both range ends. A restart whose new path crosses bands that were rejected before the restart shows whether the set of rejected bands is cleared.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    localparam int NUM_BANDS = 24;
    localparam int BAND_W    = 5;
    localparam int ADC_W     = 3;

    typedef logic [BAND_W-1:0] band_t;
    typedef logic [ADC_W-1:0]  adc_t;

    typedef enum logic [1:0] {
        CLS_ACCEPT,
        CLS_LOW,
        CLS_HIGH
    } adc_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SAMPLE
    } srch_state_e;

    typedef struct packed {
        band_t idx;
        logic  edge_hit;
    } step_res_t;

    // Outer codes push the band index; the four middle codes sit in the safe window.
    function automatic adc_cls_e classify(adc_t code);
        case (code)
            3'b000, 3'b001: return CLS_LOW;
            3'b110, 3'b111: return CLS_HIGH;
            default:        return CLS_ACCEPT;
        endcase
    endfunction

    function automatic band_t clamp_band(band_t b);
        return (int'(b) >= NUM_BANDS) ? band_t'(NUM_BANDS - 1) : b;
    endfunction

endpackage

// File: rtl/vbs_settle_timer.sv
module vbs_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load_i)        cnt_q <= load_val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    a_r6_countdown: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/vbs_reject_map.sv
module vbs_reject_map #(
    parameter int NB = 24,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          mark_i,
    input  logic [IW-1:0] mark_idx_i,
    input  logic [IW-1:0] probe_idx_i,
    output logic          hit_o
);
    logic [NB-1:0] seen_q;
    logic [NB-1:0] set_vec;
    logic [NB-1:0] probe_vec;

    for (genvar g = 0; g < NB; g++) begin : g_slot
        assign set_vec[g]   = mark_i && (mark_idx_i == IW'(g));
        assign probe_vec[g] = (probe_idx_i == IW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) seen_q <= '0;
        else                seen_q <= seen_q | set_vec;
    end

    assign hit_o = |(seen_q & probe_vec);

    a_r11_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (seen_q == '0));

    a_r5_marks_stick: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((seen_q & $past(seen_q)) == $past(seen_q)));

endmodule

// File: rtl/vbs_step_eval.sv
module vbs_step_eval #(
    parameter int NB = 24,
    parameter int IW = 5
) (
    input  logic          up_i,
    input  logic [IW-1:0] band_i,
    output logic [IW-1:0] next_o,
    output logic          edge_o
);
    localparam logic [IW-1:0] TOP_IDX = IW'(NB - 1);

    always_comb begin
        if (up_i) begin
            edge_o = (band_i >= TOP_IDX);
            next_o = band_i + 1'b1;
        end else begin
            edge_o = (band_i == '0);
            next_o = band_i - 1'b1;
        end
    end

endmodule

// File: rtl/vco_band_search.sv
module vco_band_search
    import vbs_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                auto_en_i,
    input  logic [4:0]          band_prog_i,
    input  logic [SETTLE_W-1:0] settle_cnt_i,
    input  logic [2:0]          adc_code_i,
    input  logic                adc_read_en_i,
    input  logic                adc_latch_i,
    input  logic                cp_sel_i,
    input  logic                lock_raw_i,
    output logic [4:0]          band_o,
    output logic                search_done_o,
    output logic                search_ok_o,
    output logic                cp_auto_o,
    output logic                lock_o,
    output logic [2:0]          adc_status_o
);
    srch_state_e state_q;
    band_t       band_q;
    logic        ok_q;
    adc_t        status_q;

    band_t       prog_cl;
    adc_cls_e    cls;
    logic        start_go;
    logic        tmr_zero;
    logic        tmr_load;
    logic        rej_hit;
    logic        rej_mark;
    step_res_t   step;
    logic        stop_now;
    logic        advance;
    logic        man_latch;

    assign prog_cl   = clamp_band(band_prog_i);
    assign cls       = classify(adc_code_i);
    assign start_go  = start_i && auto_en_i;
    assign stop_now  = step.edge_hit || rej_hit;
    assign rej_mark  = (state_q == ST_SAMPLE) && auto_en_i && !start_i && (cls != CLS_ACCEPT);
    assign advance   = rej_mark && !stop_now;
    assign tmr_load  = start_go || advance;
    assign man_latch = !auto_en_i && adc_latch_i && adc_read_en_i;

    vbs_settle_timer #(.W(SETTLE_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (settle_cnt_i),
        .zero_o     (tmr_zero)
    );

    vbs_step_eval #(.NB(NUM_BANDS), .IW(BAND_W)) u_step (
        .up_i   (cls == CLS_LOW),
        .band_i (band_q),
        .next_o (step.idx),
        .edge_o (step.edge_hit)
    );

    vbs_reject_map #(.NB(NUM_BANDS), .IW(BAND_W)) u_rej (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (start_go),
        .mark_i      (rej_mark),
        .mark_idx_i  (band_q),
        .probe_idx_i (step.idx),
        .hit_o       (rej_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            band_q   <= '0;
            ok_q     <= 1'b0;
            status_q <= '0;
        end else if (start_go) begin
            state_q <= ST_SETTLE;
            band_q  <= prog_cl;
            ok_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_SETTLE: begin
                    if (!auto_en_i)    state_q <= ST_IDLE;
                    else if (tmr_zero) state_q <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    if (!auto_en_i) begin
                        state_q <= ST_IDLE;
                    end else begin
                        status_q <= adc_code_i;
                        if (cls == CLS_ACCEPT) begin
                            ok_q    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (stop_now) begin
                            state_q <= ST_IDLE;
                        end else begin
                            band_q  <= step.idx;
                            state_q <= ST_SETTLE;
                        end
                    end
                end
                default: begin
                    if (man_latch) status_q <= adc_code_i;
                end
            endcase
        end
    end

    assign band_o        = auto_en_i ? band_q : prog_cl;
    assign search_done_o = (state_q == ST_IDLE);
    assign search_ok_o   = ok_q && auto_en_i && (state_q == ST_IDLE);
    assign cp_auto_o     = cp_sel_i && auto_en_i;
    assign lock_o        = lock_raw_i && (state_q == ST_IDLE);
    assign adc_status_o  = status_q;

    a_r3_ok_implies_done: assert property (@(posedge clk) disable iff (rst)
        search_ok_o |-> search_done_o);

    a_r2_start_clears_done: assert property (@(posedge clk) disable iff (rst)
        (start_i && auto_en_i) |=> !search_done_o);

    a_r2_start_band: assert property (@(posedge clk) disable iff (rst)
        (start_i && auto_en_i) |=> (!auto_en_i || band_o == $past(prog_cl)));

    a_r10_lock_masked: assert property (@(posedge clk) disable iff (rst)
        !search_done_o |-> !lock_o);

    a_r12_abort: assert property (@(posedge clk) disable iff (rst)
        (!search_done_o && !auto_en_i && !start_i) |=> (search_done_o && !search_ok_o));

    a_r5_band_range: assert property (@(posedge clk) disable iff (rst)
        int'(band_o) < NUM_BANDS);

    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        advance |=> (band_q == $past(band_q) + 1'b1 || band_q == $past(band_q) - 1'b1));

    a_r8_status_hold: assert property (@(posedge clk) disable iff (rst)
        (!auto_en_i && !(adc_latch_i && adc_read_en_i) && state_q == ST_IDLE) |=> $stable(adc_status_o));

endmodule

// File: tb/sim_vco_band_search.sv
`timescale 1ns/1ps
module sim_vco_band_search;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       auto_en_i = 1'b0;
    logic [4:0] band_prog_i = '0;
    logic [7:0] settle_cnt_i = '0;
    logic [2:0] adc_code_i;
    logic       adc_read_en_i = 1'b0;
    logic       adc_latch_i = 1'b0;
    logic       cp_sel_i = 1'b0;
    logic       lock_raw_i = 1'b0;
    logic [4:0] band_o;
    logic       search_done_o, search_ok_o, cp_auto_o, lock_o;
    logic [2:0] adc_status_o;

    int n_tests = 0;
    int n_fail  = 0;
    int tgt     = 0;
    int mode    = 0;
    logic [2:0] man_code = 3'b000;
    bit use_man = 1'b0;

    always #5 clk = ~clk;

    vco_band_search u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .auto_en_i(auto_en_i),
        .band_prog_i(band_prog_i), .settle_cnt_i(settle_cnt_i), .adc_code_i(adc_code_i),
        .adc_read_en_i(adc_read_en_i), .adc_latch_i(adc_latch_i), .cp_sel_i(cp_sel_i),
        .lock_raw_i(lock_raw_i), .band_o(band_o), .search_done_o(search_done_o),
        .search_ok_o(search_ok_o), .cp_auto_o(cp_auto_o), .lock_o(lock_o),
        .adc_status_o(adc_status_o)
    );

    // ADC model: mode 0 accepts at tgt, mode 1 bounces across tgt, mode 2..9 gives constant code mode-2.
    function automatic logic [2:0] model(int b, int t, int m);
        if (m == 0) begin
            if (b == t)          return (t % 2 == 1) ? 3'b101 : 3'b010;
            else if (b == t - 1) return 3'b001;
            else if (b < t)      return 3'b000;
            else if (b == t + 1) return 3'b110;
            else                 return 3'b111;
        end else if (m == 1) begin
            return (b <= t) ? 3'b001 : 3'b110;
        end
        return 3'(m - 2);
    endfunction

    always_comb adc_code_i = use_man ? man_code : model(int'(band_o), tgt, mode);

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Start a search at a negedge and check edge count, band, flags and captured code.
    task automatic run_search(int s, int n, int v, int eb, int eok, int est, string req);
        int cnt;
        settle_cnt_i = 8'(n);
        band_prog_i  = 5'(s);
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 1;
        chk(search_done_o == 1'b0, "R2 done low after start", int'(search_done_o), 0);
        chk(lock_o == 1'b0, "R10 lock masked", int'(lock_o), 0);
        while (search_done_o == 1'b0 && cnt < 3000) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 1 + v * (n + 2), {req, " R6 done edge"}, cnt, 1 + v * (n + 2));
        chk(int'(band_o) == eb, {req, " final band"}, int'(band_o), eb);
        chk(int'(search_ok_o) == eok, {req, " R3 ok flag"}, int'(search_ok_o), eok);
        chk(int'(adc_status_o) == est, {req, " R9 status code"}, int'(adc_status_o), est);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int sc, v, eb, est, eok, stat_before;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(search_done_o == 1'b1, "R1 done after reset", int'(search_done_o), 1);
        chk(search_ok_o == 1'b0, "R1 ok after reset", int'(search_ok_o), 0);
        chk(adc_status_o == 3'b000, "R1 status after reset", int'(adc_status_o), 0);

        // R7 manual band follows clamped programmed value
        for (int p = 0; p < 32; p++) begin
            band_prog_i = 5'(p);
            @(negedge clk);
            chk(int'(band_o) == ((p > 23) ? 23 : p), "R7 manual band", int'(band_o), (p > 23) ? 23 : p);
        end

        // R13 charge-pump hand-off
        for (int k = 0; k < 4; k++) begin
            cp_sel_i  = k[0];
            auto_en_i = k[1];
            @(negedge clk);
            chk(cp_auto_o == (k == 3), "R13 cp hand-off", int'(cp_auto_o), int'(k == 3));
        end
        auto_en_i = 1'b0;
        cp_sel_i  = 1'b0;

        // R10 lock passes when idle
        lock_raw_i = 1'b1;
        @(negedge clk);
        chk(lock_o == 1'b1, "R10 lock idle", int'(lock_o), 1);

        // R8 manual latch
        use_man = 1'b1;
        man_code = 3'b110;
        adc_latch_i = 1'b1;
        adc_read_en_i = 1'b0;
        @(negedge clk);
        adc_latch_i = 1'b0;
        chk(adc_status_o == 3'b000, "R8 latch ignored without read enable", int'(adc_status_o), 0);
        adc_read_en_i = 1'b1;
        adc_latch_i = 1'b1;
        @(negedge clk);
        adc_latch_i = 1'b0;
        chk(adc_status_o == 3'b110, "R8 latch captures code", int'(adc_status_o), 6);
        man_code = 3'b011;
        @(negedge clk);
        chk(adc_status_o == 3'b110, "R8 status held without latch", int'(adc_status_o), 6);

        // R2 start ignored in manual mode
        band_prog_i = 5'd9;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk(search_done_o == 1'b1, "R2 start ignored when disabled", int'(search_done_o), 1);
        chk(search_ok_o == 1'b0, "R3 ok low when disabled", int'(search_ok_o), 0);
        use_man = 1'b0;
        adc_read_en_i = 1'b0;

        auto_en_i = 1'b1;
        // R4 every code from a middle band
        for (int c = 0; c < 8; c++) begin
            mode = 2 + c;
            if (c <= 1)      begin v = 12; eb = 23; eok = 0; end
            else if (c >= 6) begin v = 13; eb = 0;  eok = 0; end
            else             begin v = 1;  eb = 12; eok = 1; end
            run_search(12, 1, v, eb, eok, c, "R4 code class");
        end

        // R4 R7 sweep: every start index against every target
        mode = 0;
        for (int s = 0; s < 32; s++) begin
            for (int t = 0; t < 24; t++) begin
                tgt = t;
                sc = (s > 23) ? 23 : s;
                v = ((sc > t) ? sc - t : t - sc) + 1;
                run_search(s, 1, v, t, 1, (t % 2 == 1) ? 5 : 2, "R4 R7 sweep");
            end
        end

        // R5 bounce sweep: revisiting a rejected band fails
        mode = 1;
        for (int s = 0; s < 24; s++) begin
            for (int t = 0; t < 23; t++) begin
                tgt = t;
                if (s <= t) begin v = t + 2 - s; eb = t + 1; est = 6; end
                else        begin v = s - t + 1; eb = t;     est = 1; end
                run_search(s, 0, v, eb, 0, est, "R5 bounce");
            end
        end

        // R6 longer settle times
        mode = 0;
        tgt = 4;
        run_search(10, 5, 7, 4, 1, 2, "R6 settle 5");
        run_search(3, 17, 2, 4, 1, 2, "R6 settle 17");

        // R9 latch in auto mode has no effect
        stat_before = int'(adc_status_o);
        use_man = 1'b1;
        man_code = 3'b111;
        adc_read_en_i = 1'b1;
        adc_latch_i = 1'b1;
        @(negedge clk);
        adc_latch_i = 1'b0;
        adc_read_en_i = 1'b0;
        use_man = 1'b0;
        chk(int'(adc_status_o) == stat_before, "R9 latch ignored in auto", int'(adc_status_o), stat_before);

        // R11 restart clears rejected set: tries 2,3,4 then restart at 8 toward 3
        tgt = 20;
        settle_cnt_i = 8'd1;
        band_prog_i = 5'd2;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (9) @(negedge clk);
        chk(int'(band_o) == 5, "R11 band before restart", int'(band_o), 5);
        tgt = 3;
        run_search(8, 1, 6, 3, 1, 5, "R11 restart");

        // R12 abort by clearing the enable
        tgt = 20;
        band_prog_i = 5'd1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        auto_en_i = 1'b0;
        @(negedge clk);
        chk(search_done_o == 1'b1, "R12 abort done", int'(search_done_o), 1);
        chk(search_ok_o == 1'b0, "R12 abort ok", int'(search_ok_o), 0);
        chk(lock_o == 1'b1, "R10 lock after abort", int'(lock_o), 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule